// File: doc/BRIEF.md
# Scanline Timer with Processor Stall

This block sets the horizontal rhythm of a video chip whose pixel (colour) clock runs three times faster than the processor attached to it. A position counter walks across every scanline one colour clock at a time. The block flags the blanking stretch at the start of each line. It also produces a clock enable that marks the colour clocks on which the processor may take a bus cycle.

The processor can ask to be synchronised to the beam by writing a strobe register. The bus decode raises `sync_wr` during that write. The block holds `rdy` low from then on and lets the processor go again exactly when the counter returns to position zero. Position zero is the start of blanking, not its end. The block also pulses `line_start` on every wrap. Vertical timing, the processor and pixel generation are outside this block.

Top module: `scanline_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `hpos` = 0, `rdy` = 1, `line_start` = 0 and `cpu_ce` = 1. Reset is synchronous and active high.
- R2: Out of reset, `hpos` rises by one on every clock and goes from 227 back to 0, so a line is 228 colour clocks.
- R3: `hblank` is 1 exactly when `hpos` is below 68, so 0 to 67 are blank and 68 is the first visible position.
- R4: `cpu_ce` is 1 exactly when `hpos` is a multiple of 3, which includes position 0. One processor cycle therefore spans three colour clocks.
- R5: `line_start` is 1 for exactly the cycles whose `hpos` is 0 and that follow a wrap from 227. It stays 0 during the first line after reset.
- R6: When `sync_wr` is 1 in a cycle with `cpu_ce` = 1, `rdy` is 0 from the next cycle on. It stays 0 until the cycle in which `hpos` is 0, and in that cycle it is 1 again.
- R7: `sync_wr` in a cycle with `cpu_ce` = 0 is ignored, and `rdy` stays 1.
- R8: After a release at position 0, count the enabled cycles from the release cycle (cycle 0). Cycle n falls on `hpos` = 3n, so cycle 23 is on position 69, one clock after blanking ends.
- R9: `sync_wr` asserted again while the processor is already stalled does not move the release point. `rdy` still returns at the next position 0.
- R10: A reset in the middle of a line, while stalled, brings `hpos` back to 0 and `rdy` back to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_wr | input | 1 | Processor write to the sync strobe register, honoured only on enabled cycles |
| hpos | output | 8 | Colour-clock position within the line, 0 to 227 |
| hblank | output | 1 | Horizontal blank flag |
| cpu_ce | output | 1 | Processor clock enable, every third colour clock |
| rdy | output | 1 | Processor ready, low while stalled |
| line_start | output | 1 | One-cycle pulse on the position-0 cycle after a wrap |

## Verification
`hpos`, `hblank` and `cpu_ce` follow one clock after the edge that moves the counter. `line_start` and the fall of `rdy` come in the cycle after the wrap edge or the enabled strobe edge. The return of `rdy` lines up with `hpos` reaching 0. The bench drives inputs on the falling edge and compares every output on the next falling edge. It compares against a state model that it advances at each rising edge from the inputs it applied, so each result is checked in exactly the cycle it is due. Directed runs time the release and count enabled cycles up to position 69.

// File: rtl/sl_timing_pkg.sv
package sl_timing_pkg;

  // Next counter position with wrap at the end of a line.
  function automatic int step_pos(input int p, input int len);
    return (p >= len - 1) ? 0 : p + 1;
  endfunction

  // True while the position lies inside horizontal blank.
  function automatic bit is_blank(input int p, input int blank_len);
    return p < blank_len;
  endfunction

  // True when the position sits on a processor-cycle boundary.
  function automatic bit is_phase0(input int p, input int div);
    return (p % div) == 0;
  endfunction

endpackage

// File: rtl/sl_line_counter.sv
module sl_line_counter
  import sl_timing_pkg::*;
#(
  parameter int LINE_CLKS = 228,
  parameter int POS_W     = $clog2(LINE_CLKS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             at_end,
  output logic             line_start
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_CLKS - 1);

  assign at_end = (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      line_start <= 1'b0;
    end else begin
      pos        <= POS_W'(step_pos(int'(pos), LINE_CLKS));
      line_start <= at_end;
    end
  end

  // R2: single step per clock, wrap at the last position
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> (pos == $past(pos) + 1'b1));
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (pos == '0));
  a_r2_range: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < LINE_CLKS);
  // R5: pulse only at position zero
  a_r5_pulse_pos: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (pos == '0));

endmodule

// File: rtl/sl_ce_div.sv
module sl_ce_div #(
  parameter int CE_DIV = 3,
  parameter int PH_W   = (CE_DIV > 1) ? $clog2(CE_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic ce
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CE_DIV - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || phase == PH_LAST) phase <= '0;
    else                         phase <= phase + 1'b1;
  end

  assign ce = (phase == '0);

  generate
    if (CE_DIV > 1) begin : g_gap
      // R4: enables never fall on back-to-back colour clocks
      a_r4_gap: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce);
    end
  endgenerate

endmodule

// File: rtl/sl_stall_ctl.sv
module sl_stall_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic sync_wr,
  input  logic at_end,
  output logic rdy
);

  logic stalled;
  logic take_req;

  assign take_req = ce && sync_wr;

  always_ff @(posedge clk) begin
    if (rst || at_end) stalled <= 1'b0;
    else if (take_req) stalled <= 1'b1;
  end

  assign rdy = !stalled;

  // R6: an enabled strobe drops ready on the next cycle
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (ce && sync_wr && !at_end) |=> !rdy);
  // R6 / R9: stall holds until the line end
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!rdy && !at_end) |=> !rdy);
  // R7: strobes outside enabled cycles never start a stall
  a_r7_ignore: assert property (@(posedge clk) disable iff (rst)
    (!ce && rdy) |=> rdy);

endmodule

// File: rtl/scanline_timer.sv
module scanline_timer
  import sl_timing_pkg::*;
#(
  parameter int LINE_CLKS  = 228,
  parameter int BLANK_CLKS = 68,
  parameter int CE_DIV     = 3,
  parameter int POS_W      = $clog2(LINE_CLKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_wr,
  output logic [POS_W-1:0] hpos,
  output logic             hblank,
  output logic             cpu_ce,
  output logic             rdy,
  output logic             line_start
);

  logic line_end;

  sl_line_counter #(.LINE_CLKS(LINE_CLKS), .POS_W(POS_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .pos        (hpos),
    .at_end     (line_end),
    .line_start (line_start)
  );

  sl_ce_div #(.CE_DIV(CE_DIV)) u_ce (
    .clk (clk),
    .rst (rst),
    .ce  (cpu_ce)
  );

  sl_stall_ctl u_stall (
    .clk     (clk),
    .rst     (rst),
    .ce      (cpu_ce),
    .sync_wr (sync_wr),
    .at_end  (line_end),
    .rdy     (rdy)
  );

  assign hblank = is_blank(int'(hpos), BLANK_CLKS);

  // R4: the divider stays phase-locked to the line counter
  a_r4_align: assert property (@(posedge clk) disable iff (rst)
    cpu_ce == is_phase0(int'(hpos), CE_DIV));
  // R6: processor always runs at line position zero
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (hpos == '0) |-> rdy);
  // R3: blank ends exactly at the configured width
  a_r3_blank_end: assert property (@(posedge clk) disable iff (rst)
    $fell(hblank) |-> (int'(hpos) == BLANK_CLKS));

endmodule

// File: tb/scanline_timer_bench.sv
module scanline_timer_bench;

  localparam int LINE = 228;
  localparam int BLANK = 68;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_wr = 1'b0;
  logic [7:0] hpos;
  logic       hblank, cpu_ce, rdy, line_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int m_pos = 0;
  bit m_ls = 0;
  bit m_stall = 0;
  // observed values from the latest step
  int o_pos;
  bit o_ce, o_rdy, o_blank, o_ls;

  always #10 clk = ~clk;

  scanline_timer u_scanline_timer (
    .clk(clk), .rst(rst), .sync_wr(sync_wr), .hpos(hpos),
    .hblank(hblank), .cpu_ce(cpu_ce), .rdy(rdy), .line_start(line_start)
  );

  function automatic bit exp_ce(int p);    return (p % DIV) == 0; endfunction
  function automatic bit exp_blank(int p); return p < BLANK;      endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input bit rs);
    @(negedge clk);
    o_pos = int'(hpos); o_ce = cpu_ce; o_rdy = rdy; o_blank = hblank; o_ls = line_start;
    chk("R2 hpos", o_pos, m_pos);
    chk("R3 hblank", int'(o_blank), int'(exp_blank(m_pos)));
    chk("R4 cpu_ce", int'(o_ce), int'(exp_ce(m_pos)));
    chk("R5 line_start", int'(o_ls), int'(m_ls));
    chk("R6 rdy", int'(o_rdy), int'(!m_stall));
    sync_wr = wr;
    rst = rs;
    @(posedge clk);
    if (rs) begin
      m_pos = 0; m_ls = 0; m_stall = 0;
    end else begin
      if (m_pos == LINE - 1) m_stall = 0;
      else if (exp_ce(m_pos) && wr) m_stall = 1;
      m_ls = (m_pos == LINE - 1);
      m_pos = (m_pos == LINE - 1) ? 0 : m_pos + 1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int cnt;
    void'($urandom(32'd1234));
    step(0, 1);
    step(0, 1);
    // R1: reset values
    step(0, 0);
    chk("R1 hpos", o_pos, 0);
    chk("R1 rdy", int'(o_rdy), 1);
    chk("R1 line_start", int'(o_ls), 0);
    chk("R1 cpu_ce", int'(o_ce), 1);

    // R5: no pulse through the first line, pulse after the wrap
    do step(0, 0); while (o_pos != LINE - 1);
    step(0, 0);
    chk("R5 pulse after wrap", int'(o_ls), 1);

    // R7: strobe on a non-enabled cycle has no effect
    while (exp_ce(m_pos) || m_pos > 200) step(0, 0);
    step(1, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0);
      chk("R7 rdy stays high", int'(o_rdy), 1);
    end

    // R6 / R8: enabled strobe, release at zero, cycle 23 on 69
    while (!exp_ce(m_pos) || m_pos < 90) step(0, 0);
    step(1, 0);
    step(0, 0);
    chk("R6 rdy low after strobe", int'(o_rdy), 0);
    // R9: repeated strobe while stalled
    while (!exp_ce(m_pos)) step(0, 0);
    step(1, 0);
    do step(0, 0); while (o_pos != 0);
    chk("R9 released at zero", int'(o_rdy), 1);
    chk("R6 release at zero", int'(o_ce), 1);
    cnt = 0;
    while (cnt < 23) begin
      step(0, 0);
      if (o_ce && o_rdy) cnt++;
    end
    chk("R8 cycle 23 position", o_pos, 69);
    chk("R8 visible at 69", int'(o_blank), 0);

    // R3: blank boundary
    do step(0, 0); while (o_pos != BLANK - 1);
    chk("R3 last blank", int'(o_blank), 1);
    step(0, 0);
    chk("R3 first visible", int'(o_blank), 0);

    // R10: reset while stalled mid-line
    while (!exp_ce(m_pos)) step(0, 0);
    step(1, 0);
    step(0, 0);
    step(0, 1);
    step(0, 0);
    chk("R10 hpos after reset", o_pos, 0);
    chk("R10 rdy after reset", int'(o_rdy), 1);

    // random traffic
    for (int i = 0; i < 20000; i++) begin
      bit w, r;
      w = ($urandom % 8) == 0;
      r = ($urandom % 3000) == 0;
      step(w, r);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule